// File: doc/BRIEF.md
# Multi-Endpoint Transmit FIFO Partitioner

This block splits one shared packet RAM into several independent transmit FIFOs, one for each IN endpoint. A 32-bit configuration word places each FIFO: the low half gives the first RAM word of its region and the high half gives its depth in words. Endpoint 0 reads its word from a port of its own. The other endpoints read theirs from one packed vector. The lowest `RX_WORDS` words of the RAM belong to the receive region, so every transmit region has to lie above that area.

The system-bus side pushes words into the FIFO of a chosen endpoint. The link side pops words from the FIFO of the endpoint it is sending. Both can act in the same cycle, because the RAM has a write port and a separate read port. Each FIFO keeps its own read offset, write offset and occupancy count. Both offsets wrap inside the FIFO's region. For each FIFO the block reports full, empty, the number of free words, and sticky overflow and underflow flags. A flush input for each FIFO empties that FIFO without touching the others.

Top module: `txf_partition`

## Requirements
- R1: After reset every FIFO is empty, every error flag is 0, `pop_valid_o` is 0, and each FIFO's free-word count equals its configured depth.
- R2: Words popped from a FIFO come out in the order they were pushed. Each accepted pop drives `pop_valid_o` high with the word on `pop_data_o` in the next cycle.
- R3: A FIFO word lives at RAM address start + offset. The offset returns to 0 when it reaches the depth, so after exactly depth pushes the next word is stored at the region's start address again.
- R4: A push to a full FIFO stores nothing and sets that FIFO's bit in `ovf_err_o`.
- R5: A pop from an empty FIFO leaves `pop_valid_o` low in the next cycle and sets that FIFO's bit in `unf_err_o`.
- R6: Error bits stay set until reset. A flush does not clear them.
- R7: Asserting `flush_i[k]` empties FIFO k and returns both of its offsets to 0 in one cycle. Other FIFOs are left alone. A push or pop to FIFO k in the same cycle is dropped and raises no error.
- R8: `free_words_o` field k (bits 16k+15:16k) equals depth minus occupancy. `full_o[k]` is set when occupancy equals the depth. `empty_o[k]` is set when occupancy is 0.
- R9: A push and a pop in the same cycle both take effect, whether they target different FIFOs or the same one.
- R10: Endpoint 0 takes its word from `cfg_ep0_i`. Endpoint k≥1 takes bits 32(k-1)+31:32(k-1) of `cfg_ep_i`. In each word, bits 15:0 hold the start address and bits 31:16 hold the depth.
- R11: A region is disabled when its start is below `RX_WORDS` or when start + depth exceeds the RAM size. A disabled region reports full=1, empty=1 and zero free words, and every push to it is rejected as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ep0_i | input | 32 | Region word for endpoint 0 ({depth, start}) |
| cfg_ep_i | input | 32*(NUM_EP-1) | Region words for endpoints 1 and up, packed |
| push_i | input | 1 | Bus push request |
| push_ep_i | input | EP_W | Endpoint targeted by the push |
| push_data_i | input | DATA_W | Word to push |
| pop_i | input | 1 | Link pop request |
| pop_ep_i | input | EP_W | Endpoint targeted by the pop |
| pop_data_o | output | DATA_W | Popped word, valid one cycle after the pop |
| pop_valid_o | output | 1 | `pop_data_o` holds an accepted pop |
| flush_i | input | NUM_EP | Flush for each FIFO |
| full_o | output | NUM_EP | Full flag for each FIFO |
| empty_o | output | NUM_EP | Empty flag for each FIFO |
| free_words_o | output | 16*NUM_EP | Free words for each FIFO, 16 bits per field |
| ovf_err_o | output | NUM_EP | Sticky overflow flag for each FIFO |
| unf_err_o | output | NUM_EP | Sticky underflow flag for each FIFO |

## Verification
Directed sequences cover several cases:
- Filling a depth-3 FIFO past its limit, which shows a rejected push from an accepted one.
- Popping an empty FIFO.
- A flush in the same cycle as a push.
- Pushes and pops in the same cycle, both to one FIFO and to two different FIFOs.

A second region is deliberately overlapped with the first after a full wrap. The word it overwrites then shows whether the physical address is really start + offset and whether the offset came back to 0. Out-of-bounds region words check the disable rule.

A long seeded random phase follows. It mixes pushes, pops and occasional flushes on all endpoints. A queue model in the bench checks the data order, the status flags and the free counts against the design after every cycle.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int FLD_W = 16;
    localparam int CFG_W = 2 * FLD_W;

    // Configuration word: depth in the upper half, start address in the lower half
    typedef struct packed {
        logic [FLD_W-1:0] depth;
        logic [FLD_W-1:0] start;
    } txf_cfg_t;

    // Per-FIFO registered state
    typedef struct packed {
        logic [FLD_W-1:0] wr_off;
        logic [FLD_W-1:0] rd_off;
        logic [FLD_W-1:0] count;
        logic             ovf;
        logic             unf;
    } txf_state_t;
endpackage

// File: rtl/txf_ram.sv
module txf_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rdata_q;

    // Write port (bus side)
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    // Registered read port (link side)
    always_ff @(posedge clk) begin
        if (re_i) rdata_q <= mem[raddr_i];
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
    import txf_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int RX_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  txf_cfg_t          cfg_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              flush_i,
    output logic              push_ok_o,
    output logic              pop_ok_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              full_o,
    output logic              empty_o,
    output logic [FLD_W-1:0]  free_o,
    output logic              ovf_o,
    output logic              unf_o
);
    localparam int              RAM_WORDS = 1 << ADDR_W;
    localparam logic [FLD_W:0]  RAM_END   = RAM_WORDS[FLD_W:0];
    localparam logic [FLD_W-1:0] RX_LIM   = RX_WORDS[FLD_W-1:0];

    txf_state_t       st_d, st_q;
    logic [FLD_W:0]   end_addr;
    logic             region_ok;
    logic [FLD_W-1:0] eff_depth;
    logic [FLD_W-1:0] wr_nxt, rd_nxt;

    always_comb begin
        // Region validity: above the receive area and inside the RAM
        end_addr  = {1'b0, cfg_i.start} + {1'b0, cfg_i.depth};
        region_ok = (cfg_i.start >= RX_LIM) && (end_addr <= RAM_END);
        eff_depth = region_ok ? cfg_i.depth : '0;

        push_ok_o = push_i && !flush_i && (st_q.count < eff_depth);
        pop_ok_o  = pop_i && !flush_i && (st_q.count != '0);

        // Offsets wrap to zero at the region depth
        wr_nxt = st_q.wr_off + 16'd1;
        if (wr_nxt == eff_depth) wr_nxt = '0;
        rd_nxt = st_q.rd_off + 16'd1;
        if (rd_nxt == eff_depth) rd_nxt = '0;

        st_d = st_q;
        if (flush_i) begin
            st_d.wr_off = '0;
            st_d.rd_off = '0;
            st_d.count  = '0;
        end else begin
            if (push_ok_o) st_d.wr_off = wr_nxt;
            if (pop_ok_o)  st_d.rd_off = rd_nxt;
            if (push_ok_o && !pop_ok_o)      st_d.count = st_q.count + 16'd1;
            else if (!push_ok_o && pop_ok_o) st_d.count = st_q.count - 16'd1;
            if (push_i && !push_ok_o) st_d.ovf = 1'b1;
            if (pop_i && !pop_ok_o)   st_d.unf = 1'b1;
        end

        // Physical address = start + offset (modulo RAM size)
        wr_addr_o = cfg_i.start[ADDR_W-1:0] + st_q.wr_off[ADDR_W-1:0];
        rd_addr_o = cfg_i.start[ADDR_W-1:0] + st_q.rd_off[ADDR_W-1:0];

        full_o  = (st_q.count >= eff_depth);
        empty_o = (st_q.count == '0);
        free_o  = full_o ? '0 : (eff_depth - st_q.count);
        ovf_o   = st_q.ovf;
        unf_o   = st_q.unf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: rejected push raises overflow and leaves the write offset alone
    p_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !flush_i) |=> (ovf_o && $stable(st_q.wr_off)));

    // R5: rejected pop raises underflow and leaves the read offset alone
    p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !flush_i) |=> (unf_o && $stable(st_q.rd_off)));

    // R6: error flags are sticky
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);

    // R7: a flush leaves the FIFO empty with both offsets at zero
    p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (empty_o && st_q.wr_off == '0 && st_q.rd_off == '0));

    // R3: offsets stay inside the region
    p_offset_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr_off == '0 || st_q.wr_off < eff_depth) &&
        (st_q.rd_off == '0 || st_q.rd_off < eff_depth));
endmodule

// File: rtl/txf_partition.sv
module txf_partition
    import txf_pkg::*;
#(
    parameter int NUM_EP   = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int RX_WORDS = 32,
    localparam int EP_W    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CFG_W-1:0]            cfg_ep0_i,
    input  logic [CFG_W*(NUM_EP-1)-1:0] cfg_ep_i,
    input  logic                        push_i,
    input  logic [EP_W-1:0]             push_ep_i,
    input  logic [DATA_W-1:0]           push_data_i,
    input  logic                        pop_i,
    input  logic [EP_W-1:0]             pop_ep_i,
    output logic [DATA_W-1:0]           pop_data_o,
    output logic                        pop_valid_o,
    input  logic [NUM_EP-1:0]           flush_i,
    output logic [NUM_EP-1:0]           full_o,
    output logic [NUM_EP-1:0]           empty_o,
    output logic [FLD_W*NUM_EP-1:0]     free_words_o,
    output logic [NUM_EP-1:0]           ovf_err_o,
    output logic [NUM_EP-1:0]           unf_err_o
);
    txf_cfg_t          cfg_v   [NUM_EP];
    logic [ADDR_W-1:0] wr_addr_v [NUM_EP];
    logic [ADDR_W-1:0] rd_addr_v [NUM_EP];
    logic [FLD_W-1:0]  free_v  [NUM_EP];
    logic [NUM_EP-1:0] push_sel, pop_sel, push_ok, pop_ok;

    logic              ram_we, ram_re;
    logic [ADDR_W-1:0] ram_waddr, ram_raddr;
    logic              vld_d, vld_q;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        if (g == 0) begin : g_cfg0
            assign cfg_v[g] = txf_cfg_t'(cfg_ep0_i);
        end else begin : g_cfgn
            assign cfg_v[g] = txf_cfg_t'(cfg_ep_i[CFG_W*(g-1) +: CFG_W]);
        end

        assign push_sel[g] = push_i && (push_ep_i == EP_W'(g));
        assign pop_sel[g]  = pop_i  && (pop_ep_i  == EP_W'(g));

        txf_ctrl #(
            .ADDR_W   (ADDR_W),
            .RX_WORDS (RX_WORDS)
        ) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_i     (cfg_v[g]),
            .push_i    (push_sel[g]),
            .pop_i     (pop_sel[g]),
            .flush_i   (flush_i[g]),
            .push_ok_o (push_ok[g]),
            .pop_ok_o  (pop_ok[g]),
            .wr_addr_o (wr_addr_v[g]),
            .rd_addr_o (rd_addr_v[g]),
            .full_o    (full_o[g]),
            .empty_o   (empty_o[g]),
            .free_o    (free_v[g]),
            .ovf_o     (ovf_err_o[g]),
            .unf_o     (unf_err_o[g])
        );

        assign free_words_o[g*FLD_W +: FLD_W] = free_v[g];
    end

    // Port address muxes: at most one FIFO is granted per port
    always_comb begin
        ram_we    = |push_ok;
        ram_re    = |pop_ok;
        ram_waddr = '0;
        ram_raddr = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (push_ok[i]) ram_waddr = wr_addr_v[i];
            if (pop_ok[i])  ram_raddr = rd_addr_v[i];
        end
        vld_d = ram_re;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
    end

    txf_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .waddr_i (ram_waddr),
        .wdata_i (push_data_i),
        .re_i    (ram_re),
        .raddr_i (ram_raddr),
        .rdata_o (pop_data_o)
    );

    assign pop_valid_o = vld_q;

    // R9: each RAM port serves at most one FIFO per cycle
    p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_ok) && $onehot0(pop_ok));

    // R5: a pop to an empty FIFO yields no data next cycle
    p_no_data_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o[pop_ep_i]) |=> !pop_valid_o);
endmodule

// File: tb/txf_partition_test.sv
module txf_partition_test;
    localparam int N   = 4;
    localparam int DW  = 32;
    localparam int RXW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   cfg0;
    logic [95:0]   cfgx;
    logic          push, pop;
    logic [1:0]    push_ep, pop_ep;
    logic [DW-1:0] push_data;
    logic [N-1:0]  flush;
    logic [DW-1:0] pop_data;
    logic          pop_valid;
    logic [N-1:0]  full, empty, ovf, unf;
    logic [63:0]   free_words;

    int n_chk = 0;
    int n_err = 0;

    // Reference model
    int          m_start [N];
    int          m_depth [N];
    int          m_head  [N];
    int          m_cnt   [N];
    logic [31:0] m_buf   [N][64];
    bit          m_ovf   [N];
    bit          m_unf   [N];
    logic [31:0] last_pop;

    always #5 clk = ~clk;

    txf_partition #(.NUM_EP(N), .ADDR_W(8), .DATA_W(DW), .RX_WORDS(RXW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_ep0_i(cfg0), .cfg_ep_i(cfgx),
        .push_i(push), .push_ep_i(push_ep), .push_data_i(push_data),
        .pop_i(pop), .pop_ep_i(pop_ep), .pop_data_o(pop_data), .pop_valid_o(pop_valid),
        .flush_i(flush), .full_o(full), .empty_o(empty), .free_words_o(free_words),
        .ovf_err_o(ovf), .unf_err_o(unf)
    );

    function automatic int eff(int e);
        if (m_start[e] >= RXW && m_start[e] + m_depth[e] <= 256) return m_depth[e];
        return 0;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(int e, int start, int depth);
        logic [31:0] w;
        w = {depth[15:0], start[15:0]};
        m_start[e] = start;
        m_depth[e] = depth;
        if (e == 0) cfg0 = w;
        else        cfgx[32*(e-1) +: 32] = w;
    endtask

    task automatic check_status();
        for (int e = 0; e < N; e++) begin
            chk("R8", $sformatf("full[%0d]", e),  full[e],  m_cnt[e] >= eff(e));
            chk("R8", $sformatf("empty[%0d]", e), empty[e], m_cnt[e] == 0);
            chk("R8", $sformatf("free[%0d]", e),  free_words[16*e +: 16], eff(e) - m_cnt[e]);
            chk("R4", $sformatf("ovf[%0d]", e),   ovf[e], m_ovf[e]);
            chk("R5", $sformatf("unf[%0d]", e),   unf[e], m_unf[e]);
        end
    endtask

    // Called at a falling edge; applies one cycle of stimulus and checks at the next falling edge
    task automatic step(bit pv, int pe, logic [31:0] pd, bit qv, int qe, logic [N-1:0] fl);
        bit          acc_push, acc_pop;
        bit          exp_valid;
        logic [31:0] exp_data;
        push = pv; push_ep = pe[1:0]; push_data = pd;
        pop = qv;  pop_ep = qe[1:0];  flush = fl;
        acc_push  = pv && !fl[pe] && (m_cnt[pe] < eff(pe));
        acc_pop   = qv && !fl[qe] && (m_cnt[qe] > 0);
        exp_valid = acc_pop;
        exp_data  = '0;
        if (pv && !fl[pe] && !acc_push) m_ovf[pe] = 1;
        if (qv && !fl[qe] && !acc_pop)  m_unf[qe] = 1;
        if (acc_pop) begin
            exp_data = m_buf[qe][m_head[qe]];
            m_head[qe] = (m_head[qe] + 1) % 64;
            m_cnt[qe]--;
        end
        if (acc_push) begin
            m_buf[pe][(m_head[pe] + m_cnt[pe]) % 64] = pd;
            m_cnt[pe]++;
        end
        for (int e = 0; e < N; e++) if (fl[e]) m_cnt[e] = 0;
        @(posedge clk);
        @(negedge clk);
        push = 0; pop = 0; flush = '0;
        chk("R2", "pop_valid", pop_valid, exp_valid);
        if (exp_valid) begin
            chk("R2", "pop_data", pop_data, exp_data);
            last_pop = pop_data;
        end
        check_status();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, '0);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        push = 0; pop = 0; flush = '0; push_ep = 0; pop_ep = 0; push_data = 0;
        cfg0 = '0; cfgx = '0; last_pop = '0;
        for (int e = 0; e < N; e++) begin
            m_head[e] = 0; m_cnt[e] = 0; m_ovf[e] = 0; m_unf[e] = 0;
        end
        set_cfg(0, 32, 8);
        set_cfg(1, 40, 4);
        set_cfg(2, 48, 16);
        set_cfg(3, 64, 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R10: reset state and per-endpoint config decoding
        chk("R1", "pop_valid", pop_valid, 0);
        chk("R1", "empty", empty, 4'hF);
        chk("R1", "ovf", ovf, 0);
        chk("R1", "unf", unf, 0);
        chk("R10", "free ep0", free_words[15:0], 8);
        chk("R10", "free ep1", free_words[31:16], 4);
        chk("R10", "free ep2", free_words[47:32], 16);
        chk("R10", "free ep3", free_words[63:48], 3);

        // R2: ordered data on ep0
        step(1, 0, 32'hA000_0001, 0, 0, '0);
        step(1, 0, 32'hA000_0002, 0, 0, '0);
        step(1, 0, 32'hA000_0003, 0, 0, '0);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 0, 1, 0, '0);
            chk("R2", "ordered word", last_pop, 32'hA000_0001 + i);
        end

        // R9: push and pop in the same cycle, different and same FIFOs
        step(1, 0, 32'hB000_0000, 0, 0, '0);
        step(1, 1, 32'hB100_0000, 1, 0, '0);
        chk("R9", "cross pop data", last_pop, 32'hB000_0000);
        chk("R9", "ep1 free after cross push", free_words[31:16], 3);
        step(1, 1, 32'hB100_0001, 1, 1, '0);
        chk("R9", "same-fifo pop data", last_pop, 32'hB100_0000);
        chk("R9", "ep1 free unchanged", free_words[31:16], 3);
        step(0, 0, 0, 1, 1, '0);

        // R4: overflow on ep3 (depth 3)
        for (int i = 0; i < 4; i++) step(1, 3, 32'hC000_0000 + i, 0, 0, '0);
        chk("R4", "ovf ep3", ovf[3], 1);
        chk("R4", "full ep3", full[3], 1);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 0, 1, 3, '0);
            chk("R4", "kept word", last_pop, 32'hC000_0000 + i);
        end

        // R5: underflow on ep2
        step(0, 0, 0, 1, 2, '0);
        chk("R5", "no valid on empty pop", pop_valid, 0);
        chk("R5", "unf ep2", unf[2], 1);

        // R7: flush one FIFO with a colliding push, others untouched
        step(1, 0, 32'hD000_0000, 0, 0, '0);
        step(1, 0, 32'hD000_0001, 0, 0, '0);
        step(1, 1, 32'hD100_0000, 0, 0, '0);
        step(1, 0, 32'hD000_0002, 0, 0, 4'b0001);
        chk("R7", "ep0 empty after flush", empty[0], 1);
        chk("R7", "ep0 free after flush", free_words[15:0], 8);
        chk("R7", "no ovf from flushed push", ovf[0], 0);
        chk("R7", "ep1 untouched", free_words[31:16], 3);
        step(0, 0, 0, 1, 1, '0);
        chk("R7", "ep1 data kept", last_pop, 32'hD100_0000);

        // R6: flush does not clear sticky errors
        step(0, 0, 0, 0, 0, 4'b1100);
        chk("R6", "ovf ep3 sticky", ovf[3], 1);
        chk("R6", "unf ep2 sticky", unf[2], 1);

        // R3: wrap and physical addressing via deliberate overlap
        step(0, 0, 0, 0, 0, 4'b0010);
        for (int i = 0; i < 4; i++) step(1, 1, 32'hE000_0000 + i, 0, 0, '0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, '0);
        step(1, 1, 32'hE100_000A, 0, 0, '0);
        step(1, 1, 32'hE100_000B, 0, 0, '0);
        set_cfg(3, 40, 2);
        idle();
        step(1, 3, 32'hE300_0099, 0, 0, '0);
        m_buf[1][m_head[1]] = 32'hE300_0099;
        step(0, 0, 0, 1, 1, '0);
        chk("R3", "alias at region start after wrap", last_pop, 32'hE300_0099);
        step(0, 0, 0, 1, 1, '0);
        chk("R3", "second word at start+1", last_pop, 32'hE100_000B);
        step(0, 0, 0, 0, 0, 4'b1000);
        set_cfg(3, 64, 3);
        idle();

        // R11: disabled regions
        set_cfg(2, 16, 8);
        idle();
        chk("R11", "low region full", full[2], 1);
        chk("R11", "low region empty", empty[2], 1);
        chk("R11", "low region free", free_words[47:32], 0);
        step(1, 2, 32'hF000_0000, 0, 0, '0);
        chk("R11", "push rejected", ovf[2], 1);
        set_cfg(2, 250, 16);
        idle();
        chk("R11", "high region free", free_words[47:32], 0);
        chk("R11", "high region full", full[2], 1);
        set_cfg(2, 48, 16);
        idle();
        chk("R11", "restored region free", free_words[47:32], 16);

        // Random phase
        void'($urandom(32'd1357));
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] fl;
            fl = '0;
            for (int e = 0; e < N; e++) fl[e] = ($urandom_range(99) < 3);
            step($urandom_range(99) < 60, $urandom_range(3), $urandom,
                 $urandom_range(99) < 50, $urandom_range(3), fl);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule